// File: doc/BRIEF.md
# CRT raster timing generator

This block paces a raster display from a character clock, one tick per group of eight pixels. A bank of byte-wide control registers sets the line and frame geometry. The block then drives horizontal and vertical sync, horizontal and vertical blanking, and a combined display-enable. It also supplies the video memory fetch logic with a per-frame start address and a per-row address.

Most geometry values are stored with a fixed bias, so the register value is not the count itself. Sync and blank pulses begin on a full-width compare against the counter. They end when only the low bits of the counter match, so a pulse may cross a wrap of those low bits. The ninth and tenth bits of the vertical values are packed into one shared extension register. A protect bit can lock the horizontal bank against writes. Double scan shows every scan row twice.

Top module: `crt_timing_gen`

## Requirements
- R1: A line lasts (reg0 + 5) character clocks, where reg0 is the horizontal total byte at address 0.
- R2: `display_en_o` is high while the horizontal count is at most the horizontal display byte (address 1) and the row count is at most the 10-bit vertical display value. That value is {reg7 bit 6, reg7 bit 1, reg8}. A frame with double scan off therefore has (reg1+1)*(vdisp+1) enabled clocks.
- R3: Horizontal sync goes active on the clock whose count equals reg4 (8-bit compare). It stays active until the low 5 count bits equal reg5[4:0], giving a width of (reg5 - reg4) mod 32 clocks, where 0 means 32. Horizontal blank behaves the same way, with its start in reg2 and its 5-bit end in reg3.
- R4: A frame lasts (vtotal + 2) rows, where vtotal = {reg7 bit 5, reg7 bit 0, reg6}. The row count advances only at the end of a line.
- R5: Vertical sync starts on the row equal to {reg7 bit 7, reg7 bit 2, reg9}. It lasts (reg10[3:0] - start) mod 16 rows, where 0 means 16. Vertical blank starts on the row equal to {reg7 bit 3, reg11} and ends when the low 8 row bits equal reg12.
- R6: When reg13 bit 7 is set (double scan), every row is shown for two lines. This doubles the frame length and the vertical pulse widths in lines.
- R7: While reg10 bit 7 is set, writes to addresses 0 to 7 are ignored. Address 10 itself always accepts writes.
- R8: `frame_start_o` is a one-clock pulse on the first clock of each frame. `start_addr_o` takes {reg14, reg15} at that point only, so a write made mid-frame appears at the next frame start.
- R9: `row_addr_o` equals the start address on the first row. It then grows by 2*reg16 at each row advance.
- R10: Polarity input 1 makes a sync output active-high, and 0 makes it active-low. Each sync output has its own polarity input.
- R11: In reset, all registers and counters are zero, both sync pulses are inactive, both blank outputs and `frame_start_o` are 0, and both address outputs are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Character clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 5 | Register address, 0 to 16 |
| wr_data | input | 8 | Register write data |
| hsync_pol | input | 1 | 1 = active-high horizontal sync |
| vsync_pol | input | 1 | 1 = active-high vertical sync |
| hsync_o | output | 1 | Horizontal sync |
| vsync_o | output | 1 | Vertical sync |
| hblank_o | output | 1 | Horizontal blank, active high |
| vblank_o | output | 1 | Vertical blank, active high |
| display_en_o | output | 1 | Active picture area |
| frame_start_o | output | 1 | First clock of a frame |
| start_addr_o | output | 16 | Start address latched at frame start |
| row_addr_o | output | 16 | Address of the current row |

## Verification
The pulse flags are sticky, so a wrong count or a missed end compare leaves sync or blank stuck for a whole line or a whole frame. That error shows up within one frame as a wrong count of active clocks. A wrong wrap point changes the spacing of `frame_start_o` at once. A lost double-scan phase halves or doubles the frame length. Errors in the address path appear at the next frame start, or one line later in `row_addr_o`.

// File: rtl/crt_timing_gen.sv
module crt_timing_gen #(
  parameter int NREG      = 17,
  parameter int ROW_SHIFT = 1
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        wr_en,
  input  logic [4:0]  wr_addr,
  input  logic [7:0]  wr_data,
  input  logic        hsync_pol,
  input  logic        vsync_pol,
  output logic        hsync_o,
  output logic        vsync_o,
  output logic        hblank_o,
  output logic        vblank_o,
  output logic        display_en_o,
  output logic        frame_start_o,
  output logic [15:0] start_addr_o,
  output logic [15:0] row_addr_o
);
  localparam int HC_W = 9;
  localparam int VC_W = 11;
  localparam int LOCK_N = 8;

  logic [7:0] cr [NREG];
  logic [HC_W-1:0] hcnt, hcnt_n;
  logic [VC_W-1:0] vcnt, vcnt_n, vlast;
  logic [9:0] vtot10, vdisp10, vss10;
  logic hwrap, vstep, vwrap, scan_odd, dscan, lock;
  logic hsync_q, hblank_q, vsync_q, vblank_q, fs_q;
  logic [15:0] start_q, row_q;
  logic [8*LOCK_N-1:0] lo_bank;

  assign lock    = cr[10][7];
  assign dscan   = cr[13][7];
  assign vtot10  = {cr[7][5], cr[7][0], cr[6]};
  assign vdisp10 = {cr[7][6], cr[7][1], cr[8]};
  assign vss10   = {cr[7][7], cr[7][2], cr[9]};
  assign vlast   = {1'b0, vtot10} + 11'd1;

  always_comb
    for (int i = 0; i < LOCK_N; i++) lo_bank[8*i +: 8] = cr[i];

  always_ff @(posedge clk)
    if (!rst_n) begin
      for (int i = 0; i < NREG; i++) cr[i] <= '0;
    end else if (wr_en && (int'(wr_addr) < NREG) && !(lock && (int'(wr_addr) < LOCK_N))) begin
      cr[wr_addr] <= wr_data;
    end

  assign hwrap  = hcnt >= ({1'b0, cr[0]} + 9'd4);
  assign hcnt_n = hwrap ? '0 : hcnt + 9'd1;
  assign vstep  = hwrap && (!dscan || scan_odd);
  assign vwrap  = vstep && (vcnt >= vlast);
  assign vcnt_n = vwrap ? '0 : vcnt + 11'd1;

  always_ff @(posedge clk)
    if (!rst_n) begin
      hcnt     <= '0;
      vcnt     <= '0;
      scan_odd <= 1'b0;
      hsync_q  <= 1'b0;
      hblank_q <= 1'b0;
      vsync_q  <= 1'b0;
      vblank_q <= 1'b0;
      fs_q     <= 1'b0;
      start_q  <= '0;
      row_q    <= '0;
    end else begin
      hcnt     <= hcnt_n;
      hsync_q  <= (hcnt_n == {1'b0, cr[4]}) || (hsync_q && (hcnt_n[4:0] != cr[5][4:0]));
      hblank_q <= (hcnt_n == {1'b0, cr[2]}) || (hblank_q && (hcnt_n[4:0] != cr[3][4:0]));
      if (hwrap) scan_odd <= dscan && !scan_odd;
      if (vstep) begin
        vcnt     <= vcnt_n;
        vsync_q  <= (vcnt_n == {1'b0, vss10}) || (vsync_q && (vcnt_n[3:0] != cr[10][3:0]));
        vblank_q <= (vcnt_n == {2'b00, cr[7][3], cr[11]}) || (vblank_q && (vcnt_n[7:0] != cr[12]));
      end
      fs_q <= vwrap;
      if (vwrap) begin
        start_q <= {cr[14], cr[15]};
        row_q   <= {cr[14], cr[15]};
      end else if (vstep) begin
        row_q <= row_q + (16'(cr[16]) << ROW_SHIFT);
      end
    end

  assign hsync_o       = hsync_pol ? hsync_q : !hsync_q;
  assign vsync_o       = vsync_pol ? vsync_q : !vsync_q;
  assign hblank_o      = hblank_q;
  assign vblank_o      = vblank_q;
  assign display_en_o  = (hcnt <= {1'b0, cr[1]}) && (vcnt <= {1'b0, vdisp10});
  assign frame_start_o = fs_q;
  assign start_addr_o  = start_q;
  assign row_addr_o    = row_q;

  AST_LOCKED_BANK: assert property (@(posedge clk) disable iff (!rst_n)
    (lock && wr_en && wr_addr < 5'd8) |=> $stable(lo_bank)); // R7
  AST_ROW_ONLY_AT_LINE_END: assert property (@(posedge clk) disable iff (!rst_n)
    !hwrap |=> $stable(vcnt)); // R4
  AST_FRAME_ORIGIN: assert property (@(posedge clk) disable iff (!rst_n)
    fs_q |-> (hcnt == '0 && vcnt == '0)); // R8
  AST_FRAME_PULSE_SHORT: assert property (@(posedge clk) disable iff (!rst_n)
    fs_q |=> !fs_q); // R8
  AST_ROW_FROM_START: assert property (@(posedge clk) disable iff (!rst_n)
    fs_q |-> (row_q == start_q)); // R9
endmodule

// File: tb/crt_timing_gen_tb.sv
module crt_timing_gen_tb;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic wr_en = 1'b0;
  logic [4:0] wr_addr = '0;
  logic [7:0] wr_data = '0;
  logic hsync_pol = 1'b1;
  logic vsync_pol = 1'b1;
  logic hsync_o, vsync_o, hblank_o, vblank_o, display_en_o, frame_start_o;
  logic [15:0] start_addr_o, row_addr_o;

  int n_chk = 0;
  int n_bad = 0;

  always #10 clk = !clk;

  crt_timing_gen u_dut (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .hsync_pol(hsync_pol), .vsync_pol(vsync_pol), .hsync_o(hsync_o), .vsync_o(vsync_o),
    .hblank_o(hblank_o), .vblank_o(vblank_o), .display_en_o(display_en_o),
    .frame_start_o(frame_start_o), .start_addr_o(start_addr_o), .row_addr_o(row_addr_o)
  );

  // addr 0..13 programmed per vector
  localparam logic [7:0] REGS [4][14] = '{
    '{8'd15, 8'd11, 8'd12, 8'd19, 8'd13, 8'd17, 8'd8, 8'h00, 8'd5, 8'd7, 8'd9, 8'd6, 8'd9, 8'h00},
    '{8'd40, 8'd2, 8'd3, 8'd10, 8'd4, 8'd4, 8'd4, 8'h00, 8'd3, 8'd1, 8'd4, 8'd4, 8'd5, 8'h80},
    '{8'd3, 8'd3, 8'd4, 8'd6, 8'd5, 8'd7, 8'd4, 8'h05, 8'd9, 8'd0, 8'd3, 8'd10, 8'd20, 8'h00},
    '{8'd3, 8'd0, 8'd6, 8'd7, 8'd2, 8'd3, 8'd0, 8'h20, 8'd0, 8'd10, 8'd10, 8'd100, 8'd110, 8'h00}
  };
  // frame clocks, hsync active, hblank, vsync active, vblank, display_en
  localparam int EXP [4][6] = '{
    '{200, 40, 70, 40, 60, 72},
    '{540, 384, 84, 270, 90, 24},
    '{2096, 524, 524, 24, 80, 40},
    '{4112, 514, 514, 128, 80, 1}
  };

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic wr(input int a, input int d);
    @(negedge clk);
    wr_en = 1'b1; wr_addr = 5'(a); wr_data = 8'(d);
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic load(input int v);
    wr(10, int'(REGS[v][10]) & 8'h7f);
    for (int a = 0; a < 14; a++) wr(a, int'(REGS[v][a]));
  endtask

  task automatic wait_fs();
    int g = 0;
    do begin @(negedge clk); g++; end while (!frame_start_o && g < 20000);
  endtask

  task automatic measure(output int r[6]);
    for (int k = 0; k < 6; k++) r[k] = 0;
    wait_fs(); wait_fs(); wait_fs();
    do begin
      r[0]++;
      if (hsync_o == hsync_pol) r[1]++;
      if (hblank_o) r[2]++;
      if (vsync_o == vsync_pol) r[3]++;
      if (vblank_o) r[4]++;
      if (display_en_o) r[5]++;
      @(negedge clk);
    end while (!frame_start_o && r[0] < 20000);
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog actual=%0d expected=%0d", 190000, 0);
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    int r[6];
    repeat (3) @(negedge clk);
    // R11 reset state
    check(hsync_o == 1'b0, "R11 hsync", int'(hsync_o), 0);
    check(vsync_o == 1'b0, "R11 vsync", int'(vsync_o), 0);
    check(!hblank_o && !vblank_o, "R11 blank", int'({hblank_o, vblank_o}), 0);
    check(frame_start_o == 1'b0, "R11 frame_start", int'(frame_start_o), 0);
    check(start_addr_o == 16'd0 && row_addr_o == 16'd0, "R11 addr", int'(start_addr_o), 0);
    rst_n = 1'b1;

    // table: R1 R2 R3 R4 R5 R6 (vector 1 double scan, vectors 2/3 overflow bits)
    for (int v = 0; v < 4; v++) begin
      load(v);
      measure(r);
      check(r[0] == EXP[v][0], "R1/R4/R6 frame clocks", r[0], EXP[v][0]);
      check(r[1] == EXP[v][1], "R3 hsync clocks", r[1], EXP[v][1]);
      check(r[2] == EXP[v][2], "R3 hblank clocks", r[2], EXP[v][2]);
      check(r[3] == EXP[v][3], "R5/R6 vsync clocks", r[3], EXP[v][3]);
      check(r[4] == EXP[v][4], "R5 vblank clocks", r[4], EXP[v][4]);
      check(r[5] == EXP[v][5], "R2 display_en clocks", r[5], EXP[v][5]);
    end

    // R10 active-low sync
    load(0);
    hsync_pol = 1'b0; vsync_pol = 1'b0;
    measure(r);
    check(r[1] == 40, "R10 hsync active-low", r[1], 40);
    check(r[3] == 40, "R10 vsync active-low", r[3], 40);
    hsync_pol = 1'b1; vsync_pol = 1'b1;

    // R7 write protect
    wr(10, 8'h89);
    wr(0, 30);
    measure(r);
    check(r[0] == 200, "R7 locked write ignored", r[0], 200);
    wr(10, 8'h09);
    wr(0, 25);
    measure(r);
    check(r[0] == 300, "R7 unlock via addr 10", r[0], 300);
    wr(0, 15);

    // R8 R9 start and row address
    wr(14, 8'h12); wr(15, 8'h34); wr(16, 3);
    wait_fs(); wait_fs();
    check(start_addr_o == 16'h1234, "R8 start sampled", int'(start_addr_o), 16'h1234);
    check(row_addr_o == 16'h1234, "R9 first row", int'(row_addr_o), 16'h1234);
    @(negedge clk);
    check(frame_start_o == 1'b0, "R8 one-clock pulse", int'(frame_start_o), 0);
    repeat (19) @(negedge clk);
    check(row_addr_o == 16'h123a, "R9 second row", int'(row_addr_o), 16'h123a);
    wr(14, 8'h55);
    repeat (3) @(negedge clk);
    check(start_addr_o == 16'h1234, "R8 mid-frame write held", int'(start_addr_o), 16'h1234);
    wait_fs();
    check(start_addr_o == 16'h5534, "R8 next frame start", int'(start_addr_o), 16'h5534);

    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule